// File: doc/BRIEF.md
# Mixed-trigger primary interrupt controller

This block gathers 32 interrupt sources into one request line for a processor. Each source position is fixed when the block is built as either edge-captured or level-following. Edge positions hold a sticky bit after a rising edge until software clears it. Level positions simply mirror their input. Three of the positions do not come from the primary source vector. They carry summary lines from a secondary controller: bit 4 carries the serial/parallel summary, bit 5 the miscellaneous summary and bit 6 the audio summary.

Software uses a single-cycle register port with four words. Word 0 is the enable mask. Word 1 is the hardware latch; writing it clears edge bits. Word 2 is a software-raise register for the top software positions. Word 3 is the read-only pending view. The block produces a registered request and the index of the lowest-numbered pending, enabled source. A handler reads that index, services the source and, for an edge source, clears its latch bit.

Top module: `mixirq_top`

## Requirements
- R1: After reset, words 0, 1, 2 and 3 all read zero, `irqOut` is 0 and `irqId` is 0.
- R2: Positions 16-19, 22-24 and 28-30 are edge positions. A rising edge on such an input sets its bit in word 1 two clock edges after the input changes. The bit stays set after the input falls.
- R3: Writing word 1 clears each edge bit whose written data bit is 0 and leaves it unchanged where the data bit is 1. A rising edge that arrives in the same cycle as the clear wins, and the bit stays set.
- R4: Every other position is a level position. Its bit in word 1 equals its input as sampled two clock edges earlier, and a write to word 1 has no effect on it.
- R5: Positions 4, 5 and 6 take their value from `cascIrq[0]`, `cascIrq[1]` and `cascIrq[2]` respectively. Bits 4-6 of `primIrq` are ignored.
- R6: Word 2 stores only bits 28-30 of a write, and its other bits read 0. The source status is word 1 OR word 2.
- R7: Word 0 is read/write and takes effect on the clock edge of the write. Word 3 reads status AND mask, and writes to word 3 are ignored.
- R8: `irqOut` is 1 exactly when status AND mask was non-zero on the previous clock edge.
- R9: `irqId` gives the lowest-numbered set bit of status AND mask, registered together with `irqOut`. It is 0 when no request is raised.
- R10: `busRData` shows the word selected by `busAddr` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| primIrq | input | 32 | Primary source lines; bits 4-6 unused |
| cascIrq | input | 3 | Secondary summaries: [0] serial/parallel, [1] misc, [2] audio |
| busWr | input | 1 | Write strobe for the addressed word |
| busAddr | input | 2 | Word select: 0 mask, 1 latch, 2 software raise, 3 pending |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data of the addressed word |
| irqOut | output | 1 | Registered interrupt request |
| irqId | output | 5 | Index of the lowest pending enabled source |

## Verification
The bench builds the block with its default map: 32 positions, ten edge positions in three groups, the software-raise group at 28-30 and the cascade group at 4-6. These values bring within reach the mix of edge groups and level bits, edges that collide with clears inside one word, and priority between a cascade summary, a level bit and an edge bit. Random source pulses and random bus writes run against a cycle model of the registers, and directed sequences cover the ignored primary bits, the refused writes and the clear-versus-edge race.

// File: rtl/mixirq_pkg.sv
`timescale 1ns/1ps
package mixirq_pkg;
  localparam logic [1:0] ADDR_MASK  = 2'd0;
  localparam logic [1:0] ADDR_LATCH = 2'd1;
  localparam logic [1:0] ADDR_SOFT  = 2'd2;
  localparam logic [1:0] ADDR_PEND  = 2'd3;

  typedef struct packed {
    logic       wrMask;
    logic       wrLatch;
    logic       wrSoft;
    logic [1:0] rdSel;
  } busStrb_t;
endpackage

// File: rtl/mixirq_ctrl.sv
`timescale 1ns/1ps
module mixirq_ctrl
  import mixirq_pkg::*;
(
  input  logic       busWr,
  input  logic [1:0] busAddr,
  output busStrb_t   strb
);
  // Decode the register port into write strobes; word 3 has no strobe (R7)
  always_comb begin
    strb.wrMask  = busWr && (busAddr == ADDR_MASK);
    strb.wrLatch = busWr && (busAddr == ADDR_LATCH);
    strb.wrSoft  = busWr && (busAddr == ADDR_SOFT);
    strb.rdSel   = busAddr;
  end
endmodule

// File: rtl/mixirq_dp.sv
`timescale 1ns/1ps
module mixirq_dp
  import mixirq_pkg::*;
#(
  parameter int             SRC_W    = 32,
  parameter logic [SRC_W-1:0] EDGE_MAP = 32'h71CF_0000,
  parameter logic [SRC_W-1:0] SOFT_MAP = 32'h7000_0000,
  parameter int             CASC_LSB = 4,
  parameter int             CASC_W   = 3,
  localparam int            ID_W     = $clog2(SRC_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SRC_W-1:0]  primIrq,
  input  logic [CASC_W-1:0] cascIrq,
  input  busStrb_t          strb,
  input  logic [SRC_W-1:0]  wData,
  output logic [SRC_W-1:0]  rData,
  output logic              irqOut,
  output logic [ID_W-1:0]   irqId
);
  logic [SRC_W-1:0] srcEff, srcQ, srcPrev, riseVec, keepVec, hwNext;
  logic [SRC_W-1:0] hwLatch, softReg, maskReg, statusVec, pendVec;
  logic             unusedCascSlots;

  // Cascade summaries replace the primary lines at their positions (R5)
  for (genvar g = 0; g < SRC_W; g++) begin : g_map
    if (g >= CASC_LSB && g < CASC_LSB + CASC_W) begin : g_casc
      assign srcEff[g] = cascIrq[g - CASC_LSB];
    end else begin : g_prim
      assign srcEff[g] = primIrq[g];
    end
  end
  assign unusedCascSlots = ^primIrq[CASC_LSB +: CASC_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcQ    <= '0;
      srcPrev <= '0;
    end else begin
      srcQ    <= srcEff;
      srcPrev <= srcQ;
    end
  end

  // Edge bits: sticky, cleared by zeros in a latch write, edge wins (R2, R3)
  // Level bits: follow the registered input (R4)
  assign riseVec = srcQ & ~srcPrev & EDGE_MAP;
  assign keepVec = strb.wrLatch ? wData : '1;
  assign hwNext  = (((hwLatch & keepVec) | riseVec) & EDGE_MAP) | (srcQ & ~EDGE_MAP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hwLatch <= '0;
      softReg <= '0;
      maskReg <= '0;
    end else begin
      hwLatch <= hwNext;
      if (strb.wrSoft) softReg <= wData & SOFT_MAP;
      if (strb.wrMask) maskReg <= wData;
    end
  end

  assign statusVec = hwLatch | softReg;
  assign pendVec   = statusVec & maskReg;

  function automatic logic [ID_W-1:0] lowestSet(input logic [SRC_W-1:0] v);
    logic [ID_W-1:0] idx;
    idx = '0;
    for (int i = SRC_W - 1; i >= 0; i--) begin
      if (v[i]) idx = ID_W'(i);
    end
    return idx;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut <= 1'b0;
      irqId  <= '0;
    end else begin
      irqOut <= |pendVec;
      irqId  <= lowestSet(pendVec);
    end
  end

  always_comb begin
    case (strb.rdSel)
      ADDR_MASK:  rData = maskReg;
      ADDR_LATCH: rData = hwLatch;
      ADDR_SOFT:  rData = softReg;
      default:    rData = pendVec;
    endcase
  end

  // R8
  req_matches_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == $past(|pendVec));

  // R9
  id_is_lowest_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (($past(pendVec) & ((SRC_W'(1) << irqId) - SRC_W'(1))) == '0));

  // R9
  id_idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqOut |-> irqId == '0);

  // R4
  level_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hwLatch & ~EDGE_MAP) == $past(srcQ & ~EDGE_MAP));

  // R3
  edge_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.wrLatch) |->
      ((hwLatch & $past(hwLatch) & EDGE_MAP) == ($past(hwLatch) & EDGE_MAP)));
endmodule

// File: rtl/mixirq_top.sv
`timescale 1ns/1ps
module mixirq_top
  import mixirq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] primIrq,
  input  logic [2:0]  cascIrq,
  input  logic        busWr,
  input  logic [1:0]  busAddr,
  input  logic [31:0] busWData,
  output logic [31:0] busRData,
  output logic        irqOut,
  output logic [4:0]  irqId
);
  busStrb_t strb;

  mixirq_ctrl ctrl_i (
    .busWr   (busWr),
    .busAddr (busAddr),
    .strb    (strb)
  );

  mixirq_dp #(
    .SRC_W    (32),
    .EDGE_MAP (32'h71CF_0000),
    .SOFT_MAP (32'h7000_0000),
    .CASC_LSB (4),
    .CASC_W   (3)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .primIrq (primIrq),
    .cascIrq (cascIrq),
    .strb    (strb),
    .wData   (busWData),
    .rData   (busRData),
    .irqOut  (irqOut),
    .irqId   (irqId)
  );
endmodule

// File: tb/mixirq_top_tb.sv
`timescale 1ns/1ps
module mixirq_top_tb_top;
  localparam logic [31:0] EDGE = 32'h71CF_0000;
  localparam logic [31:0] SOFT = 32'h7000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] primIrq = '0;
  logic [2:0]  cascIrq = '0;
  logic        busWr = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic        irqOut;
  logic [4:0]  irqId;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // model state
  logic [31:0] mQ, mPrev, mHw, mSoft, mMask;
  logic        mIrq;
  logic [4:0]  mId;

  always #2.5 clk = ~clk;

  mixirq_top dut_i (.*);

  function automatic logic [4:0] lowest(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return 5'(i);
    return 5'd0;
  endfunction

  function automatic logic [31:0] effSrc(input logic [31:0] p, input logic [2:0] c);
    return (p & ~32'h70) | ({29'd0, c} << 4);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(input logic [1:0] a);
    case (a)
      2'd0: return mMask;
      2'd1: return mHw;
      2'd2: return mSoft;
      default: return (mHw | mSoft) & mMask;
    endcase
  endfunction

  // Called in the low phase with inputs already applied; checks, then clocks once.
  task automatic step(input bit wr, input logic [1:0] a, input logic [31:0] d);
    logic [31:0] nQ, nHw, nSoft, nMask, keep, pend;
    busWr = wr; busAddr = a; busWData = d;
    #1;
    chk("R10 read word", busRData, modelRead(a));
    chk("R8 request", {31'd0, irqOut}, {31'd0, mIrq});
    chk("R9 index", {27'd0, irqId}, {27'd0, mId});
    nQ    = effSrc(primIrq, cascIrq);
    keep  = (wr && a == 2'd1) ? d : '1;
    nHw   = (((mHw & keep) | (mQ & ~mPrev)) & EDGE) | (mQ & ~EDGE);
    nSoft = (wr && a == 2'd2) ? (d & SOFT) : mSoft;
    nMask = (wr && a == 2'd0) ? d : mMask;
    pend  = (mHw | mSoft) & mMask;
    @(posedge clk);
    mPrev = mQ; mQ = nQ; mHw = nHw; mSoft = nSoft; mMask = nMask;
    mIrq = |pend; mId = lowest(pend);
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic peek(input string req, input logic [1:0] a, input logic [31:0] exp);
    busWr = 1'b0; busAddr = a;
    #1;
    chk(req, busRData, exp);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    mQ = '0; mPrev = '0; mHw = '0; mSoft = '0; mMask = '0; mIrq = 0; mId = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) peek("R1 reset word", 2'(a), 32'd0);
    chk("R1 reset request", {31'd0, irqOut}, 32'd0);
    chk("R1 reset index", {27'd0, irqId}, 32'd0);

    step(1, 2'd0, 32'hFFFF_FFFF);
    // R2 edge latch on bit 17
    primIrq[17] = 1'b1; step(0, 2'd1, 0);
    primIrq[17] = 1'b0; step(0, 2'd1, 0);
    step(0, 2'd1, 0);
    peek("R2 edge held", 2'd1, 32'h0002_0000);
    step(0, 2'd1, 0);
    chk("R9 edge index", {27'd0, irqId}, 32'd17);
    // R3 clear bit 17, keep nothing else
    step(1, 2'd1, 32'hFFFD_FFFF);
    peek("R3 edge cleared", 2'd1, 32'd0);
    // R3 race: edge arrives with the clear
    primIrq[22] = 1'b1; step(0, 2'd1, 0);
    primIrq[22] = 1'b0; step(1, 2'd1, 32'd0);
    peek("R3 edge wins clear", 2'd1, 32'h0040_0000);
    step(1, 2'd1, 32'd0);
    // R4 level bit 2 not cleared by write
    primIrq[2] = 1'b1; step(0, 2'd1, 0); step(0, 2'd1, 0);
    step(1, 2'd1, 32'd0);
    peek("R4 level survives write", 2'd1, 32'h0000_0004);
    primIrq[2] = 1'b0; step(0, 2'd1, 0); step(0, 2'd1, 0);
    peek("R4 level follows input", 2'd1, 32'd0);
    // R5 primary bits 4-6 ignored, cascade drives them
    primIrq[6:4] = 3'b111; step(0, 2'd1, 0); step(0, 2'd1, 0); step(0, 2'd1, 0);
    peek("R5 primary slots ignored", 2'd1, 32'd0);
    cascIrq = 3'b010; step(0, 2'd1, 0); step(0, 2'd1, 0);
    peek("R5 misc summary on bit 5", 2'd1, 32'h0000_0020);
    step(0, 2'd3, 0);
    chk("R9 cascade index", {27'd0, irqId}, 32'd5);
    primIrq = '0; cascIrq = '0; step(0, 2'd1, 0); step(0, 2'd1, 0);
    // R6 soft register
    step(1, 2'd2, 32'hFFFF_FFFF);
    peek("R6 soft only top group", 2'd2, 32'h7000_0000);
    // R7 writes to pending ignored
    step(1, 2'd3, 32'd0);
    peek("R7 pending write ignored", 2'd3, 32'h7000_0000);
    step(1, 2'd0, 32'h2000_0000);
    peek("R7 mask applied", 2'd3, 32'h2000_0000);
    step(0, 2'd0, 0);
    chk("R9 masked index", {27'd0, irqId}, 32'd29);
    step(1, 2'd2, 32'd0);
    step(0, 2'd3, 0); step(0, 2'd3, 0);
    chk("R8 request drops", {31'd0, irqOut}, 32'd0);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom();
      primIrq = $urandom() & $urandom();
      cascIrq = 3'($urandom());
      step(r[1:0] == 2'd0, r[3:2], $urandom() | (r[4] ? 32'h0 : 32'hFFFF_0000));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule